// File: doc/BRIEF.md
# Eight-Source Vectored Interrupt Controller

This block collects interrupt requests for a small 4-bit processor core and hands the core one vector at a time. It has eight request factors. Factors 0 to 2 come from external pins, and each pin passes through a synchroniser and a rising-edge detector. Factors 3 to 7 come from internal sources such as timers and serial channels, which raise a level for one or more cycles. Each request sets a sticky flag. The flag stays set until its factor is serviced, whatever the state of the enables.

Each factor has its own enable bit. The eight enables form two 4-bit groups: the low group holds factors 0 to 3 and the high group holds factors 4 to 7. The core changes a group with a command that carries a 4-bit mask. The command either ORs the mask into the group or clears the masked bits. Separate commands set and clear a global master enable.

The block offers an interrupt to the core when the master enable is set and some factor has both its enable and its flag set. Among those factors the lowest index wins, and the block presents that factor's index and its fixed vector address. The offer is a valid/ready handshake. The offer is live and not held stable. While it waits for ready, a higher-priority factor that becomes eligible replaces it. A command that clears the master enable or the winning factor's enable withdraws it. Acceptance happens on a cycle where valid and ready are both high. On acceptance the block clears that factor's flag and the master enable, so the core must re-arm the master enable before it can take a further interrupt.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After reset all request flags, all individual enables and the master enable are clear, and irq_valid_o is low even when later enables are set with no request flag pending.
- R2: A rising edge on ext_pin_i[k] (k = 0..2), seen after a two-flop synchroniser, sets the flag of factor k. A pin that stays high gives only one request. A pulse that is at least 2 cycles high after at least 2 cycles low is always captured.
- R3: A cycle with int_req_i[j] high (j = 0..4) sets the flag of factor 3+j.
- R4: With cmd_valid_i high, op code 3'd1 sets the master enable and op code 3'd2 clears it.
- R5: Op code 3'd3 ORs cmd_mask_i into the low group, where mask bit b enables factor b. Op code 3'd4 ORs the mask into the high group, where mask bit b enables factor 4+b.
- R6: Op code 3'd5 clears the masked bits of the low group and op code 3'd6 clears the masked bits of the high group, under the same bit mapping as R5. The other group is left unchanged.
- R7: irq_valid_o is high exactly when the master enable is set and at least one factor has both its enable and its flag set.
- R8: When several factors are eligible, the lowest index wins. irq_factor_o carries that index and irq_vector_o carries 8'h10 + 8 × index.
- R9: On a cycle with irq_valid_o and irq_ready_i both high, the flag of the offered factor is cleared and the master enable is cleared. A master-set command in the same cycle takes effect after the clear.
- R10: Requests that arrive while the master enable or the factor's enable is clear stay latched, and they are offered once both enables are set.
- R11: Commands have no effect when cmd_valid_i is low, and op code 3'd0 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_pin_i | input | 3 | External request pins, asynchronous, rising-edge sensitive |
| int_req_i | input | 5 | Internal request levels, synchronous |
| cmd_valid_i | input | 1 | Command strobe |
| cmd_op_i | input | 3 | Command op code |
| cmd_mask_i | input | 4 | Command mask for group enable and disable |
| irq_valid_o | output | 1 | Interrupt offered |
| irq_ready_i | input | 1 | Core accepts the offered interrupt |
| irq_factor_o | output | 3 | Index of the offered factor |
| irq_vector_o | output | 8 | Vector address of the offered factor |

## Verification
A wrong enable or flag bit shows at the ports in the next cycle. It shows either as an offer of the wrong factor or vector, or as irq_valid_o that is high or low when it should not be, because the selection path is combinational from the state registers. A flag that fails to clear on acceptance shows as the same factor offered again once the master enable is re-armed. Lost or doubled external edges show three cycles after the pin moves, once the synchroniser and the edge register have passed the edge. The bench therefore checks the offered factor and the vector after every command and every service. A scoreboard matches each accepted vector against the expected order.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  typedef enum logic [2:0] {
    OP_NOP   = 3'd0,
    OP_MSET  = 3'd1,
    OP_MCLR  = 3'd2,
    OP_ENLO  = 3'd3,
    OP_ENHI  = 3'd4,
    OP_DISLO = 3'd5,
    OP_DISHI = 3'd6,
    OP_RSVD  = 3'd7
  } irq_op_e;
endpackage

// File: rtl/irqc_edge_sync.sv
module irqc_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  output logic rise_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], pin_i};
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign rise_o = sync_q[STAGES-1] & ~prev_q;

  // R2
  single_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rise_o |=> !rise_o);
endmodule

// File: rtl/irqc_pending.sv
module irqc_pending #(
  parameter int N  = 8,
  parameter int IW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  set_i,
  input  logic          clr_i,
  input  logic [IW-1:0] clr_idx_i,
  output logic [N-1:0]  flag_o
);
  logic [N-1:0] flag_q;
  logic [N-1:0] clr_vec;

  always_comb begin
    clr_vec = '0;
    if (clr_i) clr_vec[clr_idx_i] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= '0;
    else        flag_q <= (flag_q & ~clr_vec) | set_i;
  end

  assign flag_o = flag_q;

  for (genvar i = 0; i < N; i++) begin : g_chk
    // R10
    sticky_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_q[i] && !(clr_i && clr_idx_i == IW'(i))) |=> flag_q[i]);
    // R9
    ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i && clr_idx_i == IW'(i) && !set_i[i]) |=> !flag_q[i]);
  end
endmodule

// File: rtl/irqc_enables.sv
module irqc_enables
  import irqc_pkg::*;
#(
  parameter int GW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid_i,
  input  logic [2:0]    cmd_op_i,
  input  logic [GW-1:0] cmd_mask_i,
  input  logic          ack_i,
  output logic          master_o,
  output logic [2*GW-1:0] en_o
);
  localparam int N = 2 * GW;

  logic          master_q;
  logic [GW-1:0] lo_q, hi_q;
  irq_op_e       op;

  assign op = irq_op_e'(cmd_op_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      master_q <= 1'b0;
      lo_q     <= '0;
      hi_q     <= '0;
    end else begin
      if (cmd_valid_i && op == OP_MSET)      master_q <= 1'b1;
      else if (cmd_valid_i && op == OP_MCLR) master_q <= 1'b0;
      else if (ack_i)                        master_q <= 1'b0;
      if (cmd_valid_i) begin
        case (op)
          OP_ENLO:  lo_q <= lo_q | cmd_mask_i;
          OP_DISLO: lo_q <= lo_q & ~cmd_mask_i;
          OP_ENHI:  hi_q <= hi_q | cmd_mask_i;
          OP_DISHI: hi_q <= hi_q & ~cmd_mask_i;
          default: ;
        endcase
      end
    end
  end

  assign master_o = master_q;
  assign en_o     = {hi_q, lo_q};

  // R5
  en_lo_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid_i && cmd_op_i == 3'd3) |=> ((en_o[GW-1:0] & $past(cmd_mask_i)) == $past(cmd_mask_i)));
  // R6
  dis_hi_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid_i && cmd_op_i == 3'd6) |=> (((en_o[N-1:GW] & $past(cmd_mask_i)) == '0)
                                           && $stable(en_o[GW-1:0])));
  // R11
  idle_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmd_valid_i || cmd_op_i == 3'd0) |=> $stable(en_o));
endmodule

// File: rtl/irqc_prio.sv
module irqc_prio #(
  parameter int N  = 8,
  parameter int IW = 3
) (
  input  logic [N-1:0]  req_i,
  output logic          valid_o,
  output logic [IW-1:0] idx_o
);
  always_comb begin
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = IW'(i);
    end
  end

  assign valid_o = |req_i;

  // R8
  always_comb begin
    if (valid_o) begin
      lowest_wins_chk: assert ((req_i[idx_o] == 1'b1) &&
                               ((req_i & ((N'(1) << idx_o) - N'(1))) == '0));
    end
  end
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
  import irqc_pkg::*;
#(
  parameter int N_EXT       = 3,
  parameter int N_INT       = 5,
  parameter int GRP_W       = 4,
  parameter int SYNC_STAGES = 2,
  parameter int VEC_W       = 8,
  parameter int VEC_BASE    = 16,
  parameter int VEC_STRIDE  = 8
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic [N_EXT-1:0]                   ext_pin_i,
  input  logic [N_INT-1:0]                   int_req_i,
  input  logic                               cmd_valid_i,
  input  logic [2:0]                         cmd_op_i,
  input  logic [GRP_W-1:0]                   cmd_mask_i,
  output logic                               irq_valid_o,
  input  logic                               irq_ready_i,
  output logic [$clog2(N_EXT+N_INT)-1:0]     irq_factor_o,
  output logic [VEC_W-1:0]                   irq_vector_o
);
  localparam int N  = N_EXT + N_INT;
  localparam int IW = $clog2(N);

  logic [N_EXT-1:0] ext_rise;
  logic [N-1:0]     set_vec, flags, en;
  logic             master, sel_valid, accept;
  logic [IW-1:0]    sel_idx;

  for (genvar k = 0; k < N_EXT; k++) begin : g_ext
    irqc_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .pin_i(ext_pin_i[k]), .rise_o(ext_rise[k])
    );
  end

  assign set_vec = {int_req_i, ext_rise};
  assign accept  = irq_valid_o & irq_ready_i;

  irqc_pending #(.N(N), .IW(IW)) u_pend (
    .clk(clk), .rst_n(rst_n), .set_i(set_vec),
    .clr_i(accept), .clr_idx_i(sel_idx), .flag_o(flags)
  );

  irqc_enables #(.GW(GRP_W)) u_en (
    .clk(clk), .rst_n(rst_n), .cmd_valid_i(cmd_valid_i), .cmd_op_i(cmd_op_i),
    .cmd_mask_i(cmd_mask_i), .ack_i(accept), .master_o(master), .en_o(en)
  );

  irqc_prio #(.N(N), .IW(IW)) u_prio (
    .req_i(flags & en), .valid_o(sel_valid), .idx_o(sel_idx)
  );

  assign irq_valid_o  = master & sel_valid;
  assign irq_factor_o = sel_idx;
  assign irq_vector_o = VEC_W'(VEC_BASE) + VEC_W'(sel_idx) * VEC_W'(VEC_STRIDE);

  // R9
  ack_drops_master_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !(cmd_valid_i && cmd_op_i == 3'd1)) |=> !irq_valid_o);
  // R4
  mclr_drops_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid_i && cmd_op_i == 3'd2) |=> !irq_valid_o);
endmodule

// File: tb/sim_irq_vector_ctrl.sv
module sim_irq_vector_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] ext_pin_i = '0;
  logic [4:0] int_req_i = '0;
  logic       cmd_valid_i = 1'b0;
  logic [2:0] cmd_op_i = '0;
  logic [3:0] cmd_mask_i = '0;
  logic       irq_valid_o, irq_ready_i = 1'b0;
  logic [2:0] irq_factor_o;
  logic [7:0] irq_vector_o;

  int checks = 0, errors = 0;
  logic [7:0] exp_q[$];

  always #2 clk = ~clk;

  irq_vector_ctrl u0 (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_cmd(input logic [2:0] op, input logic [3:0] m);
    @(negedge clk);
    cmd_valid_i = 1'b1; cmd_op_i = op; cmd_mask_i = m;
    @(negedge clk);
    cmd_valid_i = 1'b0; cmd_op_i = '0; cmd_mask_i = '0;
  endtask

  task automatic pulse_int(input logic [4:0] m);
    @(negedge clk);
    int_req_i = m;
    @(negedge clk);
    int_req_i = '0;
  endtask

  task automatic expect_offer(input int f, input string req);
    chk(irq_valid_o === 1'b1, req, irq_valid_o, 1);
    chk(irq_factor_o == 3'(f), req, irq_factor_o, f);
    chk(irq_vector_o == 8'(16 + 8 * f), req, irq_vector_o, 16 + 8 * f);
  endtask

  task automatic expect_idle(input string req);
    chk(irq_valid_o === 1'b0, req, irq_valid_o, 0);
  endtask

  // driver side of the scoreboard: one accepted interrupt, then re-arm
  task automatic service(input int f);
    expect_offer(f, "R8");
    exp_q.push_back(8'(16 + 8 * f));
    irq_ready_i = 1'b1;
    @(negedge clk);
    irq_ready_i = 1'b0;
    expect_idle("R9");
    do_cmd(3'd1, 4'h0);
  endtask

  // monitor: compares each accepted vector with the expected order
  always @(posedge clk) begin
    if (rst_n && irq_valid_o && irq_ready_i) begin
      if (exp_q.size() == 0) chk(1'b0, "R8", irq_vector_o, 0);
      else begin
        logic [7:0] e;
        e = exp_q.pop_front();
        chk(irq_vector_o == e, "R8", irq_vector_o, e);
      end
    end
  end

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    expect_idle("R1");
    do_cmd(3'd1, 4'h0);
    do_cmd(3'd3, 4'hF);
    do_cmd(3'd4, 4'hF);
    expect_idle("R1");
    do_cmd(3'd2, 4'h0);

    // R3 and R10: internal requests latched while master is clear
    pulse_int(5'b11111);
    expect_idle("R10");
    do_cmd(3'd1, 4'h0);
    service(3);
    service(4);
    service(5);
    service(6);
    service(7);
    expect_idle("R9");

    // R6: factor 4 disabled in the high group
    do_cmd(3'd6, 4'b0001);
    pulse_int(5'b10010);
    @(negedge clk);
    service(7);
    expect_idle("R7");
    do_cmd(3'd4, 4'b0001);
    expect_offer(4, "R10");
    service(4);

    // R11: strobe low and op code 0 have no effect
    do_cmd(3'd2, 4'h0);
    pulse_int(5'b00001);
    @(negedge clk);
    cmd_op_i = 3'd1; cmd_mask_i = 4'hF;
    @(negedge clk);
    cmd_op_i = 3'd0;
    expect_idle("R11");
    do_cmd(3'd0, 4'hF);
    expect_idle("R11");
    do_cmd(3'd5, 4'b1000);
    do_cmd(3'd1, 4'h0);
    expect_idle("R6");
    do_cmd(3'd3, 4'b1000);
    expect_offer(3, "R5");
    service(3);

    // R2: external edge, held high gives one request
    @(negedge clk);
    ext_pin_i[2] = 1'b1;
    repeat (6) @(negedge clk);
    expect_offer(2, "R2");
    service(2);
    repeat (6) @(negedge clk);
    expect_idle("R2");
    ext_pin_i[2] = 1'b0;
    repeat (3) @(negedge clk);

    // R2 and R8: two-cycle pulses on pins 1 and 0
    ext_pin_i[1] = 1'b1;
    repeat (2) @(negedge clk);
    ext_pin_i[1] = 1'b0;
    ext_pin_i[0] = 1'b1;
    repeat (2) @(negedge clk);
    ext_pin_i[0] = 1'b0;
    repeat (6) @(negedge clk);
    service(0);
    service(1);
    expect_idle("R9");
    chk(exp_q.size() == 0, "R8", exp_q.size(), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule